// File: doc/BRIEF.md
# Consumer-Strobed Read Link

This block models, in synchronous logic, a read transfer in which the party that wants the data also owns the single timing line. A requester raises a strobe to ask a responder for a word. The responder picks that word from a small register file, using a select value taken when the strobe rises, and places it on a shared data bus after a fixed response latency. The requester holds the strobe for a programmed number of cycles. It then drops the strobe and latches the bus at that same clock edge. The responder keeps the word on the bus for a programmed number of cycles after the drop, then returns the bus to all zeros.

The register file that feeds the responder is loaded through a plain write port. A user issues `req_i` with a select value, waits for the one-cycle `done_o` pulse, and reads the captured word from `rd_data_o`. The strobe and the bus are brought out so that the link timing can be observed. While a transfer or its bus-release window is in progress, `busy_o` is high and new requests are dropped.

Cycle numbering used below: edge 0 is the first rising clock edge at which `req_i` is sampled high while `busy_o` is low. "After edge k" means the cycle that follows that edge. Defaults are LAT=2, PULSE=4, HOLD=3.

Top module: `strobe_read_link`

## Requirements
- R1: After reset, `strobe_o`, `busy_o` and `done_o` are 0, and `bus_o`, `rd_data_o` and every register-file word are all zeros.
- R2: An accepted request drives `strobe_o` high from edge 0 for exactly PULSE cycles (high after edges 0 through PULSE-1, low after edge PULSE).
- R3: The responder uses the select value presented with the request. `bus_o` is zero after edges 0 through LAT-1 and carries that register's word from edge LAT onward. A change of `req_sel_i` after edge 0 has no effect on the word.
- R4: At the strobe's falling edge (edge PULSE), `rd_data_o` loads the bus word, so after edge PULSE it equals the selected register's contents.
- R5: Once the word is on the bus, it stays unchanged until release. A write to the selected register after the load edge does not alter the word being transferred, but it does reach the register file.
- R6: `bus_o` keeps the word through the cycle after edge PULSE+HOLD-1 and reads all zeros from edge PULSE+HOLD onward (HOLD cycles after the strobe falls).
- R7: `busy_o` is high after edges 0 through PULSE+HOLD-1 and low after edge PULSE+HOLD. A request raised while `busy_o` is high never starts a transfer: the strobe stays low.
- R8: Whenever the responder is not driving the word, `bus_o` reads all zeros, including between transfers.
- R9: A write with `wr_en_i` high at a clock edge stores `wr_data_i` into word `wr_sel_i`. A later read of that word returns the stored value.
- R10: `done_o` is high for exactly one cycle per transfer, after edge PULSE. `rd_data_o` keeps the captured word until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Read request, accepted when `busy_o` is low |
| req_sel_i | input | SEL_W | Register-file word to read |
| wr_en_i | input | 1 | Register-file write enable |
| wr_sel_i | input | SEL_W | Register-file word to write |
| wr_data_i | input | DATA_W | Register-file write data |
| busy_o | output | 1 | Transfer or release window in progress |
| done_o | output | 1 | One-cycle pulse after capture |
| rd_data_o | output | DATA_W | Captured word |
| strobe_o | output | 1 | Requester-owned strobe line |
| bus_o | output | DATA_W | Shared data bus, zero when not driven |

## Verification
A responder that starts its latency count at the wrong time shows up on `bus_o` within the first LAT+1 cycles of a transfer. It can also show up as a wrong `rd_data_o` after edge PULSE. A requester counter that is off by one changes where the strobe falls, where `done_o` pulses and when `busy_o` drops, and each of these is visible within PULSE+HOLD cycles. A release counter fault leaves the bus non-zero or clears it early, and that is seen in the release window itself. The bench checks every signal in every cycle of each transfer, so a fault is reported in the cycle where it first shows.

// File: rtl/srl_pkg.sv
package srl_pkg;

    typedef enum logic [1:0] {
        RQ_IDLE   = 2'd0,
        RQ_STROBE = 2'd1,
        RQ_GUARD  = 2'd2
    } rq_state_e;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_WAIT  = 2'd1,
        RS_DRIVE = 2'd2,
        RS_HOLD  = 2'd3
    } rs_state_e;

endpackage

// File: rtl/srl_regfile.sv
module srl_regfile #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 8,
    parameter int SEL_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [DATA_W-1:0] rd_word_o
);

    logic [DATA_W-1:0] word_d [WORDS];
    logic [DATA_W-1:0] word_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_comb begin
            word_d[g] = word_q[g];
            if (wr_en_i && (wr_sel_i == SEL_W'(g))) begin
                word_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else begin
                word_q[g] <= word_d[g];
            end
        end

        // R9: a write addressed here lands one edge later
        a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && (wr_sel_i == SEL_W'(g))) |=> (word_q[g] == $past(wr_data_i)));
    end

    assign rd_word_o = word_q[rd_sel_i];

endmodule

// File: rtl/srl_requester.sv
module srl_requester
    import srl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 3,
    parameter int PULSE  = 4,
    parameter int HOLD   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              strb_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int CNT_MAX = (PULSE > HOLD) ? PULSE : HOLD;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        rq_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic              strb;
        logic [SEL_W-1:0]  sel;
        logic              done;
        logic [DATA_W-1:0] data;
    } rq_regs_t;

    rq_regs_t rq_d, rq_q;

    always_comb begin
        rq_d      = rq_q;
        rq_d.done = 1'b0;
        case (rq_q.st)
            RQ_IDLE: begin
                if (req_i) begin
                    rq_d.st   = RQ_STROBE;
                    rq_d.strb = 1'b1;
                    rq_d.cnt  = CNT_W'(PULSE - 1);
                    rq_d.sel  = sel_i;
                end
            end
            RQ_STROBE: begin
                if (rq_q.cnt == '0) begin
                    // falling strobe edge doubles as the capture edge
                    rq_d.strb = 1'b0;
                    rq_d.data = bus_i;
                    rq_d.done = 1'b1;
                    rq_d.st   = RQ_GUARD;
                    rq_d.cnt  = CNT_W'(HOLD - 1);
                end else begin
                    rq_d.cnt = rq_q.cnt - 1'b1;
                end
            end
            RQ_GUARD: begin
                if (rq_q.cnt == '0) begin
                    rq_d.st = RQ_IDLE;
                end else begin
                    rq_d.cnt = rq_q.cnt - 1'b1;
                end
            end
            default: begin
                rq_d.st   = RQ_IDLE;
                rq_d.strb = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_q <= '{st: RQ_IDLE, cnt: '0, strb: 1'b0, sel: '0, done: 1'b0, data: '0};
        end else begin
            rq_q <= rq_d;
        end
    end

    assign strb_o    = rq_q.strb;
    assign sel_o     = rq_q.sel;
    assign busy_o    = (rq_q.st != RQ_IDLE);
    assign done_o    = rq_q.done;
    assign rd_data_o = rq_q.data;

    // R4: the captured word is what the bus held just before the fall
    a_r4_capture_matches_bus: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rd_data_o == $past(bus_i)));

    // R10: done never lasts two cycles
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: no new strobe rise while a transfer or its release window runs
    a_r7_no_rise_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !$rose(strb_o));

    // R2: strobe falls only together with a capture
    a_r2_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb_o) |-> done_o);

endmodule

// File: rtl/srl_responder.sv
module srl_responder
    import srl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 3,
    parameter int LAT    = 2,
    parameter int HOLD   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [SEL_W-1:0]  rd_sel_o,
    output logic [DATA_W-1:0] bus_o
);

    localparam int CNT_MAX = (LAT > HOLD) ? LAT : HOLD;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        rs_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [SEL_W-1:0]  sel;
        logic              seen;
        logic [DATA_W-1:0] bus;
    } rs_regs_t;

    rs_regs_t rs_d, rs_q;
    logic     strb_rise;
    logic     strb_fall;

    assign strb_rise = strb_i & ~rs_q.seen;
    assign strb_fall = ~strb_i & rs_q.seen;

    always_comb begin
        rs_d      = rs_q;
        rs_d.seen = strb_i;
        case (rs_q.st)
            RS_IDLE: begin
                if (strb_rise) begin
                    rs_d.sel = sel_i;
                    if (LAT == 1) begin
                        rs_d.bus = word_i;
                        rs_d.st  = RS_DRIVE;
                    end else begin
                        rs_d.cnt = CNT_W'(LAT - 1);
                        rs_d.st  = RS_WAIT;
                    end
                end
            end
            RS_WAIT: begin
                if (rs_q.cnt == CNT_W'(1)) begin
                    rs_d.bus = word_i;
                    rs_d.st  = RS_DRIVE;
                end else begin
                    rs_d.cnt = rs_q.cnt - 1'b1;
                end
            end
            RS_DRIVE: begin
                if (strb_fall) begin
                    if (HOLD == 1) begin
                        rs_d.bus = '0;
                        rs_d.st  = RS_IDLE;
                    end else begin
                        rs_d.cnt = CNT_W'(HOLD - 1);
                        rs_d.st  = RS_HOLD;
                    end
                end
            end
            RS_HOLD: begin
                if (rs_q.cnt == CNT_W'(1)) begin
                    rs_d.bus = '0;
                    rs_d.st  = RS_IDLE;
                end else begin
                    rs_d.cnt = rs_q.cnt - 1'b1;
                end
            end
            default: begin
                rs_d.bus = '0;
                rs_d.st  = RS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= '{st: RS_IDLE, cnt: '0, sel: '0, seen: 1'b0, bus: '0};
        end else begin
            rs_q <= rs_d;
        end
    end

    // select goes straight through at the rise, then comes from the latch
    assign rd_sel_o = (rs_q.st == RS_IDLE) ? sel_i : rs_q.sel;
    assign bus_o    = rs_q.bus;

    // R3: the word is already on the bus when the requester drops its strobe
    a_r3_word_ready_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        strb_fall |-> (rs_q.st == RS_DRIVE));

    // R5: the driven word does not change while driving
    a_r5_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((rs_q.st == RS_DRIVE) && ($past(rs_q.st) == RS_DRIVE)) |-> $stable(bus_o));

    // R8: released bus reads zero
    a_r8_zero_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_q.st == RS_IDLE) |-> (bus_o == '0));

endmodule

// File: rtl/strobe_read_link.sv
module strobe_read_link #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 8,
    parameter int LAT    = 2,
    parameter int PULSE  = 4,
    parameter int HOLD   = 3,
    parameter int SEL_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [SEL_W-1:0]  req_sel_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              strobe_o,
    output logic [DATA_W-1:0] bus_o
);

    logic              link_strb;
    logic [SEL_W-1:0]  link_sel;
    logic [DATA_W-1:0] link_bus;
    logic [SEL_W-1:0]  rf_sel;
    logic [DATA_W-1:0] rf_word;

    srl_requester #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .PULSE  (PULSE),
        .HOLD   (HOLD)
    ) i_requester (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .sel_i     (req_sel_i),
        .bus_i     (link_bus),
        .strb_o    (link_strb),
        .sel_o     (link_sel),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .rd_data_o (rd_data_o)
    );

    srl_responder #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .LAT    (LAT),
        .HOLD   (HOLD)
    ) i_responder (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb_i   (link_strb),
        .sel_i    (link_sel),
        .word_i   (rf_word),
        .rd_sel_o (rf_sel),
        .bus_o    (link_bus)
    );

    srl_regfile #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS),
        .SEL_W  (SEL_W)
    ) i_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .rd_sel_i  (rf_sel),
        .rd_word_o (rf_word)
    );

    assign strobe_o = link_strb;
    assign bus_o    = link_bus;

endmodule

// File: tb/test_strobe_read_link.sv
module test_strobe_read_link;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int WORDS  = 8;
    localparam int LAT    = 2;
    localparam int PULSE  = 4;
    localparam int HOLD   = 3;
    localparam int SEL_W  = $clog2(WORDS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_i = 1'b0;
    logic [SEL_W-1:0]  req_sel_i = '0;
    logic              wr_en_i = 1'b0;
    logic [SEL_W-1:0]  wr_sel_i = '0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic              busy_o;
    logic              done_o;
    logic [DATA_W-1:0] rd_data_o;
    logic              strobe_o;
    logic [DATA_W-1:0] bus_o;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] shadow [WORDS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    strobe_read_link #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS),
        .LAT    (LAT),
        .PULSE  (PULSE),
        .HOLD   (HOLD)
    ) i_strobe_read_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .req_sel_i (req_sel_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .rd_data_o (rd_data_o),
        .strobe_o  (strobe_o),
        .bus_o     (bus_o)
    );

    // expected values, k = edges since the accepting edge
    function automatic logic exp_strobe(int k);
        return (k < PULSE);
    endfunction

    function automatic logic [DATA_W-1:0] exp_bus(int k, logic [DATA_W-1:0] w);
        return (k >= LAT && k < PULSE + HOLD) ? w : '0;
    endfunction

    function automatic logic exp_busy(int k);
        return (k < PULSE + HOLD);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input int sel, input logic [DATA_W-1:0] val);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_sel_i  = SEL_W'(sel);
        wr_data_i = val;
        @(negedge clk);
        wr_en_i   = 1'b0;
        shadow[sel] = val;
    endtask

    task automatic do_read(input int sel, input bit disturb, input bit poke);
        logic [DATA_W-1:0] w;
        w = shadow[sel];
        @(negedge clk);
        req_i     = 1'b1;
        req_sel_i = SEL_W'(sel);
        for (int k = 0; k <= PULSE + HOLD; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 0) begin
                req_i = 1'b0;
                if (disturb) req_sel_i = SEL_W'(sel ^ 1);  // R3 ignored after rise
            end
            check(strobe_o == exp_strobe(k), "R2 strobe", int'(strobe_o), int'(exp_strobe(k)));
            check(bus_o == exp_bus(k, w), "R3/R5/R6/R8 bus", int'(bus_o), int'(exp_bus(k, w)));
            check(busy_o == exp_busy(k), "R7 busy", int'(busy_o), int'(exp_busy(k)));
            check(done_o == (k == PULSE), "R10 done", int'(done_o), int'(k == PULSE));
            if (k == PULSE) begin
                check(rd_data_o == w, "R4 capture", int'(rd_data_o), int'(w));
            end
            if (disturb && k == LAT) begin
                wr_en_i   = 1'b1;           // R5 write after load edge
                wr_sel_i  = SEL_W'(sel);
                wr_data_i = ~w;
            end
            if (disturb && k == LAT + 1) begin
                wr_en_i = 1'b0;
                shadow[sel] = ~w;
            end
            if (poke && k == PULSE + 1) req_i = 1'b1;   // R7 request while busy
            if (poke && k == PULSE + 2) req_i = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check(strobe_o == 1'b0, "R7 no strobe after busy request", int'(strobe_o), 0);
        check(rd_data_o == w, "R10 rd_data held", int'(rd_data_o), int'(w));
        check(bus_o == '0, "R8 bus idle", int'(bus_o), 0);
    endtask

    initial begin
        repeat (2_000_000 / CLK_PERIOD) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < WORDS; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(strobe_o == 1'b0, "R1 strobe", int'(strobe_o), 0);
        check(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
        check(done_o == 1'b0, "R1 done", int'(done_o), 0);
        check(bus_o == '0, "R1 bus", int'(bus_o), 0);
        check(rd_data_o == '0, "R1 rd_data", int'(rd_data_o), 0);
        // R1 register file starts at zero: read after a nonzero capture
        write_reg(2, 16'hBEEF);
        do_read(2, 1'b0, 1'b0);
        do_read(5, 1'b0, 1'b0);
        // R9 directed writes to both ends of the file
        write_reg(0, 16'h1234);
        write_reg(WORDS - 1, 16'hFFFF);
        do_read(0, 1'b0, 1'b0);
        do_read(WORDS - 1, 1'b1, 1'b1);
        do_read(WORDS - 1, 1'b0, 1'b0);   // R5 write during transfer landed
        for (int n = 0; n < 60; n++) begin
            int nw;
            nw = int'($urandom_range(0, 2));
            for (int j = 0; j < nw; j++) begin
                write_reg(int'($urandom_range(0, WORDS - 1)), DATA_W'($urandom));
            end
            repeat (int'($urandom_range(0, 3))) @(negedge clk);
            do_read(int'($urandom_range(0, WORDS - 1)),
                    bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule